// File: doc/BRIEF.md
# SPI Master Character Shifter

This block sends and receives one 8-bit character at a time as an SPI master. A register-side client places a character on `tx_data` and pulses `start`. The character goes straight into the transmit shift register on that cycle. The block then lowers the active-low slave select, issues eight SCK cycles, shifts the character out on MOSI and gathers the same number of bits from MISO. It returns the received character on `rx_data` together with a one-cycle `done` pulse.

Three static inputs set the transfer format:

- `cpol` sets the SCK idle level.
- `cpha` picks which SCK edge of each bit carries valid data.
- `lsb_first` picks the bit order for both data lines.

SCK runs at one quarter of the system clock. Slave select is released after every character, whatever the phase setting, and stays high for at least one full SCK period before the next character can begin.

Top module: `spi_xfer_master`

## Requirements
- R1: During and straight after reset, `ss_n` is 1, `busy` is 0, `done` is 0 and `sck` sits at the idle level chosen by `cpol`.
- R2: While `ss_n` is high, `sck` rests at the `cpol` level (0 means idle low, 1 means idle high). It follows a change of `cpol` within two cycles.
- R3: Each character produces exactly 16 SCK transitions (8 full SCK cycles). Consecutive transitions are 2 system clocks apart, and SCK is back at its idle level when `ss_n` rises.
- R4: With `cpha` = 0, the first data bit is on MOSI as soon as `ss_n` falls. Every bit is valid on the leading (odd-numbered) SCK transitions. The block samples MISO on leading transitions and moves MOSI on trailing ones.
- R5: With `cpha` = 1, the block moves MOSI on leading transitions from the second one onward, so each bit is valid on the trailing (even-numbered) transitions. It samples MISO on trailing transitions.
- R6: `lsb_first` = 0 shifts bit 7 first and `lsb_first` = 1 shifts bit 0 first, on both MOSI and MISO. `rx_data` holds the received bits in the same order, so it equals the character the slave sent.
- R7: `ss_n` falls on the cycle after an accepted `start`. The first SCK transition comes 2 cycles after `ss_n` falls, and `ss_n` rises 2 cycles after the last SCK transition.
- R8: `done` is a single-cycle pulse 38 cycles after `ss_n` falls, with `ss_n` high at that time. Between characters `ss_n` stays high for at least 4 cycles.
- R9: `busy` is high from the cycle after an accepted `start` until the `done` pulse, and covers every cycle in which `ss_n` is low. A `start` that arrives while `busy` is high has no effect.
- R10: `tx_data` is captured on the accepted `start` cycle. Later changes to it do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a character when not busy |
| tx_data | input | 8 | Character to send, taken on the start cycle |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | Clock phase select |
| lsb_first | input | 1 | 1 sends and receives bit 0 first |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | 1 | Active-low slave select |
| busy | output | 1 | Character in progress |
| done | output | 1 | One-cycle end-of-character pulse |
| rx_data | output | 8 | Received character, valid at done |

## Verification
An accepted `start` shows up on `ss_n` one cycle later. The first SCK transition follows 2 cycles after that, and each later transition another 2 cycles on. `ss_n` rises 34 cycles after it fell, and `done`, carrying `rx_data`, arrives at cycle 38.

The bench samples every output on the falling clock edge. It time-stamps each `ss_n` and SCK change against a free-running cycle count and compares the gaps to these exact figures. A slave model in the bench serves MISO and collects MOSI in the active mode. A scoreboard queue pairs each `done` with the character that was started.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_XFER,
        ST_GAP
    } spi_state_e;

    // Odd-numbered transitions are leading ones (away from idle).
    function automatic logic edge_is_sample(input logic phase, input logic edge_odd);
        return phase ? !edge_odd : edge_odd;
    endfunction

    // Launch on the other transition; in phase 1 the first bit is already out.
    function automatic logic edge_is_launch(input logic phase, input logic edge_odd,
                                            input logic first_edge);
        return !edge_is_sample(phase, edge_odd) && !(phase && first_edge);
    endfunction

endpackage

// File: rtl/spi_xfer_halfper.sv
module spi_xfer_halfper #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clear || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
        tick = !clear && (cnt_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/spi_xfer_shifter.sv
module spi_xfer_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              launch,
    input  logic              sample,
    input  logic              lsb_first,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data
);
    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } shreg_t;

    shreg_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.tx = load_data;
            sh_d.rx = '0;
        end else begin
            if (launch) begin
                sh_d.tx = lsb_first ? {1'b0, sh_q.tx[DATA_W-1:1]}
                                    : {sh_q.tx[DATA_W-2:0], 1'b0};
            end
            if (sample) begin
                sh_d.rx = lsb_first ? {miso, sh_q.rx[DATA_W-1:1]}
                                    : {sh_q.rx[DATA_W-2:0], miso};
            end
        end
        mosi    = lsb_first ? sh_q.tx[0] : sh_q.tx[DATA_W-1];
        rx_data = sh_q.rx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);
    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES + 1);
    localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES);
    localparam logic [EW-1:0] GAP_HALVES_M1 = EW'(1);

    typedef struct packed {
        spi_state_e    st;
        logic [EW-1:0] edges;
        logic          sck;
        logic          ss_n;
        logic          busy;
        logic          done;
    } ctl_t;

    ctl_t r_d, r_q;

    logic          tick;
    logic          load;
    logic          do_edge;
    logic          sample_en;
    logic          launch_en;
    logic [EW-1:0] next_edge;

    spi_xfer_halfper #(.HALF_DIV(HALF_DIV)) u_halfper (
        .clk   (clk),
        .rst   (rst),
        .clear (r_q.st == ST_IDLE),
        .tick  (tick)
    );

    spi_xfer_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (tx_data),
        .launch    (launch_en),
        .sample    (sample_en),
        .lsb_first (lsb_first),
        .miso      (miso),
        .mosi      (mosi),
        .rx_data   (rx_data)
    );

    always_comb begin
        next_edge = r_q.edges + EW'(1);
        do_edge   = tick && ((r_q.st == ST_LEAD) ||
                             (r_q.st == ST_XFER && r_q.edges != LAST_EDGE));
        sample_en = do_edge && edge_is_sample(cpha, next_edge[0]);
        launch_en = do_edge && edge_is_launch(cpha, next_edge[0], next_edge == EW'(1));

        r_d      = r_q;
        r_d.done = 1'b0;
        load     = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                r_d.sck  = cpol;
                r_d.ss_n = 1'b1;
                if (start) begin
                    load      = 1'b1;
                    r_d.st    = ST_LEAD;
                    r_d.ss_n  = 1'b0;
                    r_d.busy  = 1'b1;
                    r_d.edges = '0;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    r_d.sck   = ~r_q.sck;
                    r_d.edges = next_edge;
                    r_d.st    = ST_XFER;
                end
            end
            ST_XFER: begin
                if (tick) begin
                    if (r_q.edges == LAST_EDGE) begin
                        r_d.ss_n  = 1'b1;
                        r_d.edges = '0;
                        r_d.st    = ST_GAP;
                    end else begin
                        r_d.sck   = ~r_q.sck;
                        r_d.edges = next_edge;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (r_q.edges == GAP_HALVES_M1) begin
                        r_d.st    = ST_IDLE;
                        r_d.busy  = 1'b0;
                        r_d.done  = 1'b1;
                        r_d.edges = '0;
                    end else begin
                        r_d.edges = next_edge;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        sck  = r_q.sck;
        ss_n = r_q.ss_n;
        busy = r_q.busy;
        done = r_q.done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_IDLE, edges: '0, sck: cpol, ss_n: 1'b1, busy: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic cpol,
    input logic sck,
    input logic ss_n,
    input logic busy,
    input logic done
);
    assert_sck_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (ss_n && $stable(cpol)) |-> (sck == cpol));

    assert_sck_home_at_release_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ss_n) |-> (sck == cpol));

    assert_select_after_start_R7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> !ss_n);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_deselected_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> ss_n);

    assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_select_within_busy_R9: assert property (@(posedge clk) disable iff (rst)
        !ss_n |-> busy);
endmodule

bind spi_xfer_master spi_xfer_master_chk u_chk (.*);

// File: tb/spi_xfer_master_tb.sv
module spi_xfer_master_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       lsb_first = 1'b0;
    logic       miso = 1'b0;
    logic       sck, mosi, ss_n, busy, done;
    logic [7:0] rx_data;

    always #5 clk = ~clk;

    spi_xfer_master u_dut (
        .clk(clk), .rst(rst), .start(start), .tx_data(tx_data),
        .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first),
        .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n),
        .busy(busy), .done(done), .rx_data(rx_data)
    );

    typedef struct {
        logic [7:0] tx;
        logic [7:0] sl;
        logic       pol;
        logic       pha;
        logic       lsb;
    } item_t;

    item_t exp_q[$];
    item_t cur;
    int n_checks = 0;
    int n_fail   = 0;
    int n_done   = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic bit_at(input logic [7:0] b, input int i, input logic lsb);
        return lsb ? b[i] : b[7-i];
    endfunction

    // Monitor and slave model, all at the falling edge.
    int cyc = 0;
    logic prev_ss = 1'b1, prev_sck = 1'b0;
    int t_fall = 0, t_rise = 0, t_first = 0, t_last = 0;
    bit have_rise = 1'b0;
    int edges = 0, bad_gap = 0, send_idx = 0;
    logic [7:0] cap = 8'h00;
    bit active = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (prev_ss && !ss_n) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 select without accepted start", 0, 1);
                    active = 1'b0;
                end else begin
                    cur = exp_q[0];
                    active = 1'b1;
                    if (have_rise) check(cyc - t_rise >= 4, "R8 deselect gap", cyc - t_rise, 4);
                    t_fall = cyc; edges = 0; bad_gap = 0; cap = 8'h00;
                    if (!cur.pha) begin
                        miso = bit_at(cur.sl, 0, cur.lsb);
                        send_idx = 1;
                    end else begin
                        send_idx = 0;
                    end
                end
            end else if (active && !prev_ss && !ss_n && sck != prev_sck) begin
                edges++;
                if (edges == 1) t_first = cyc;
                else if (cyc - t_last != 2) bad_gap++;
                t_last = cyc;
                if (cur.pha ? (sck == cur.pol) : (sck != cur.pol)) begin
                    cap = cur.lsb ? {mosi, cap[7:1]} : {cap[6:0], mosi};
                end else if (send_idx < 8) begin
                    miso = bit_at(cur.sl, send_idx, cur.lsb);
                    send_idx++;
                end
            end
            if (!prev_ss && ss_n && active) begin
                t_rise = cyc; have_rise = 1'b1;
                check(t_rise - t_last == 2, "R7 release after last edge", t_rise - t_last, 2);
                check(sck == cur.pol, "R3 sck idle at release", sck, cur.pol);
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 done without start", 0, 1);
                end else begin
                    cur = exp_q.pop_front();
                    check(rx_data == cur.sl, cur.pha ? "R5 R6 rx character" : "R4 R6 rx character",
                          rx_data, cur.sl);
                    check(cap == cur.tx, cur.pha ? "R5 R10 mosi character" : "R4 R10 mosi character",
                          cap, cur.tx);
                    check(edges == 16, "R3 sck transition count", edges, 16);
                    check(bad_gap == 0, "R3 half-period spacing", bad_gap, 0);
                    check(t_first - t_fall == 2, "R7 first edge delay", t_first - t_fall, 2);
                    check(cyc - t_fall == 38, "R8 done latency", cyc - t_fall, 38);
                    check(ss_n == 1'b1, "R8 deselected at done", ss_n, 1);
                end
                active = 1'b0;
                n_done++;
            end
            prev_ss = ss_n;
            prev_sck = sck;
        end
    end

    task automatic xfer(input logic [7:0] tx, input logic [7:0] sl, input logic pol,
                        input logic pha, input logic lsb, input bit poke);
        item_t it;
        int target;
        @(negedge clk);
        while (busy) @(negedge clk);
        cpol = pol; cpha = pha; lsb_first = lsb;
        repeat (2) @(negedge clk);
        check(sck == pol, "R2 idle level", sck, pol);
        it.tx = tx; it.sl = sl; it.pol = pol; it.pha = pha; it.lsb = lsb;
        exp_q.push_back(it);
        target = n_done + 1;
        start = 1'b1; tx_data = tx;
        @(negedge clk);
        start = 1'b0; tx_data = ~tx;  // R10: late change must not matter
        check(busy == 1'b1, "R9 busy after start", busy, 1);
        check(ss_n == 1'b0, "R7 select after start", ss_n, 0);
        if (poke) begin
            repeat (9) @(negedge clk);
            start = 1'b1; tx_data = 8'h5A;
            @(negedge clk);
            start = 1'b0;
        end
        while (n_done < target) @(negedge clk);
        if (poke) begin
            repeat (12) @(negedge clk);
            check(ss_n == 1'b1 && busy == 1'b0, "R9 start while busy ignored", {ss_n, busy}, 2'b10);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ss_n == 1'b1, "R1 reset select", ss_n, 1);
        check(busy == 1'b0 && done == 1'b0, "R1 reset busy/done", {busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(ss_n == 1'b1 && busy == 1'b0 && done == 1'b0, "R1 after reset", {ss_n, busy, done}, 3'b100);
        check(sck == 1'b0, "R1 sck idle", sck, 0);
        for (int m = 0; m < 8; m++) begin
            xfer(8'(8'h3C + m * 37), 8'(8'hC3 ^ (m * 53)), m[2], m[1], m[0], m == 2 || m == 5);
        end
        xfer(8'h80, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0);
        xfer(8'h01, 8'h80, 1'b1, 1'b1, 1'b1, 1'b0);
        xfer(8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R9 all characters completed", exp_q.size(), 0);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end
endmodule